// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-facing register file of a single UART channel. A host drives a 3-bit address, a write strobe, a read strobe and an 8-bit data bus. The full value of the line control register decides which bank the eight addresses reach:

- **Standard bank**: line control bit 7 is 0.
- **Divisor bank**: bit 7 is 1 and the byte is anything other than 0xBF. This bank holds the divisor bytes and an alternate-function register.
- **Enhanced bank**: the byte is exactly 0xBF. This bank holds the trigger, feature-control, enhanced-feature and four flow-control character registers.

An unlock bit in the enhanced-feature register decides whether the upper control bits of the interrupt enable, FIFO control and modem control registers can be written. While that bit is 0 those bits keep their value.

The block stores register values and presents them on dedicated outputs for the transmit, receive, baud and FIFO logic. It does no datapath work itself. The receive FIFO fill level comes in on a port so it can be read back. When both divisor bytes are zero, the divisor addresses return a fixed revision byte and a fixed device ID.

Top module: `uart_bank_regs`

## Requirements
- R1: After reset, every stored register reads 0x00 and every register output is 0.
- R2: Bank selection works as follows. Line control bit 7 = 0 selects the standard bank. Bit 7 = 1 with the byte not equal to 0xBF selects the divisor bank. The byte 0xBF selects the enhanced bank. Address 011 reaches the line control register in all three banks, and a write there takes effect on the next clock edge.
- R3: In the divisor bank, address 000 is the low divisor byte and 001 is the high divisor byte. Address 010 is the alternate-function register: bit 0 is concurrent write, bit 1 is baud-out select, bit 2 is ready-pin select. Bits 7..3 of address 010 read as 0. Divisor bytes change only through writes in this bank.
- R4: In the divisor bank, when both divisor bytes are 0x00, reading 000 returns the revision byte (default 0x01) and reading 001 returns the device ID 0x12.
- R5: In the enhanced bank, a write to 000 loads the trigger register, and a read of 000 returns the fifo_level input. Address 001 is the feature control register and 010 is the enhanced-feature register; both can be read and written.
- R6: In the enhanced bank, addresses 100, 101, 110 and 111 are the XON1, XON2, XOFF1 and XOFF2 characters, each 8 bits and readable and writable. They change only through these writes.
- R7: In the standard bank, 001 is the interrupt enable register and 010 is the FIFO control register. The FIFO control register is write-only and reads back 0x00. Address 100 is the modem control register in both the standard and divisor banks.
- R8: While enhanced-feature bit 4 is 0, writes leave interrupt-enable bits 7:4, FIFO-control bits 5:4 and modem-control bits 7:5 unchanged. While that bit is 1, all bits are written.
- R9: A read of an address with no register in the current bank returns 0x00. rdata is 0x00 whenever rd_en is low. A write to an address with no register changes no stored value; this includes standard-bank address 000, which is the transmit holding register and is outside this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| wdata | input | 8 | Write data |
| fifo_level | input | 8 | Receive FIFO fill count, returned on enhanced-bank reads of 000 |
| rdata | output | 8 | Read data |
| lcr_o | output | 8 | Line control register |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| mcr_o | output | 8 | Modem control register |
| dll_o | output | 8 | Divisor low byte |
| dlm_o | output | 8 | Divisor high byte |
| afr_o | output | 3 | Alternate-function bits (ready select, baud-out select, concurrent write) |
| trg_o | output | 8 | Trigger level register |
| fctr_o | output | 8 | Feature control register |
| efr_o | output | 8 | Enhanced-feature register (bit 4 unlocks the upper control bits) |
| xon1_o | output | 8 | XON1 character |
| xon2_o | output | 8 | XON2 character |
| xoff1_o | output | 8 | XOFF1 character |
| xoff2_o | output | 8 | XOFF2 character |

## Verification
The assertions check several properties on every cycle:
- The locked upper interrupt-enable bits keep their value.
- The divisor bytes and the flow-control characters keep their value unless a write in their own bank reaches them.
- A line-control write lands on the next edge.
- rdata stays zero without a read strobe.
- The ID appears whenever the divisor is zero.

Three things only the bench's sweeps can show:
- That each address reaches the right register in each of the three banks.
- That writes to unmapped or write-only addresses are dropped.
- That the gated bits of the FIFO and modem control registers follow the unlock bit.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [1:0] {
    BANK_STD = 2'd0,
    BANK_DIV = 2'd1,
    BANK_ENH = 2'd2
  } bank_e;

  localparam logic [DW-1:0] ENH_KEY = 8'hBF;

  // masks of bits that stay writable while the unlock bit is 0
  localparam logic [DW-1:0] IER_OPEN = 8'h0F;
  localparam logic [DW-1:0] FCR_OPEN = 8'hCF;
  localparam logic [DW-1:0] MCR_OPEN = 8'h1F;

  localparam logic [AW-1:0] A_0 = 3'd0;
  localparam logic [AW-1:0] A_1 = 3'd1;
  localparam logic [AW-1:0] A_2 = 3'd2;
  localparam logic [AW-1:0] A_LCR = 3'd3;
  localparam logic [AW-1:0] A_4 = 3'd4;
endpackage

// File: rtl/uart_bank_sel.sv
module uart_bank_sel
  import uart_bank_pkg::*;
(
  input  logic [DW-1:0] lcr,
  output bank_e         bank
);
  always_comb begin
    if (lcr == ENH_KEY)  bank = BANK_ENH;
    else if (lcr[DW-1])  bank = BANK_DIV;
    else                 bank = BANK_STD;
  end
endmodule

// File: rtl/uart_bank_reg.sv
module uart_bank_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = (q & ~wmask) | (d & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_MASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask)))); // R8
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_pkg::*;
#(
  parameter logic [7:0] DEV_ID  = 8'h12,
  parameter logic [7:0] DEV_REV = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] fifo_level,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] lcr_o,
  output logic [DW-1:0] ier_o,
  output logic [DW-1:0] fcr_o,
  output logic [DW-1:0] mcr_o,
  output logic [DW-1:0] dll_o,
  output logic [DW-1:0] dlm_o,
  output logic [2:0]    afr_o,
  output logic [DW-1:0] trg_o,
  output logic [DW-1:0] fctr_o,
  output logic [DW-1:0] efr_o,
  output logic [DW-1:0] xon1_o,
  output logic [DW-1:0] xon2_o,
  output logic [DW-1:0] xoff1_o,
  output logic [DW-1:0] xoff2_o
);
  localparam int NXC = 4;
  localparam logic [DW-1:0] ALL = '1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  bank_e bank;
  uart_bank_sel u_sel (.lcr(lcr_o), .bank(bank));

  logic std_b, div_b, enh_b, unlock;
  assign std_b  = (bank == BANK_STD);
  assign div_b  = (bank == BANK_DIV);
  assign enh_b  = (bank == BANK_ENH);
  assign unlock = efr_o[4];

  // write enables per register
  logic we_lcr, we_ier, we_fcr, we_mcr, we_dll, we_dlm, we_afr;
  logic we_trg, we_fctr, we_efr;
  always_comb begin
    we_lcr  = wr_en && (addr == A_LCR);
    we_ier  = wr_en && std_b && (addr == A_1);
    we_fcr  = wr_en && std_b && (addr == A_2);
    we_mcr  = wr_en && !enh_b && (addr == A_4);
    we_dll  = wr_en && div_b && (addr == A_0);
    we_dlm  = wr_en && div_b && (addr == A_1);
    we_afr  = wr_en && div_b && (addr == A_2);
    we_trg  = wr_en && enh_b && (addr == A_0);
    we_fctr = wr_en && enh_b && (addr == A_1);
    we_efr  = wr_en && enh_b && (addr == A_2);
  end

  logic [DW-1:0] ier_mask, fcr_mask, mcr_mask;
  assign ier_mask = unlock ? ALL : IER_OPEN;
  assign fcr_mask = unlock ? ALL : FCR_OPEN;
  assign mcr_mask = unlock ? ALL : MCR_OPEN;

  uart_bank_reg #(.W(DW)) u_lcr  (.clk(clk), .rst_n(rst_q), .we(we_lcr),  .wmask(ALL),      .d(wdata),      .q(lcr_o));
  uart_bank_reg #(.W(DW)) u_ier  (.clk(clk), .rst_n(rst_q), .we(we_ier),  .wmask(ier_mask), .d(wdata),      .q(ier_o));
  uart_bank_reg #(.W(DW)) u_fcr  (.clk(clk), .rst_n(rst_q), .we(we_fcr),  .wmask(fcr_mask), .d(wdata),      .q(fcr_o));
  uart_bank_reg #(.W(DW)) u_mcr  (.clk(clk), .rst_n(rst_q), .we(we_mcr),  .wmask(mcr_mask), .d(wdata),      .q(mcr_o));
  uart_bank_reg #(.W(DW)) u_dll  (.clk(clk), .rst_n(rst_q), .we(we_dll),  .wmask(ALL),      .d(wdata),      .q(dll_o));
  uart_bank_reg #(.W(DW)) u_dlm  (.clk(clk), .rst_n(rst_q), .we(we_dlm),  .wmask(ALL),      .d(wdata),      .q(dlm_o));
  uart_bank_reg #(.W(3))  u_afr  (.clk(clk), .rst_n(rst_q), .we(we_afr),  .wmask(3'b111),   .d(wdata[2:0]), .q(afr_o));
  uart_bank_reg #(.W(DW)) u_trg  (.clk(clk), .rst_n(rst_q), .we(we_trg),  .wmask(ALL),      .d(wdata),      .q(trg_o));
  uart_bank_reg #(.W(DW)) u_fctr (.clk(clk), .rst_n(rst_q), .we(we_fctr), .wmask(ALL),      .d(wdata),      .q(fctr_o));
  uart_bank_reg #(.W(DW)) u_efr  (.clk(clk), .rst_n(rst_q), .we(we_efr),  .wmask(ALL),      .d(wdata),      .q(efr_o));

  // flow-control characters at 100..111 of the enhanced bank
  logic [DW-1:0] xch [NXC];
  for (genvar i = 0; i < NXC; i++) begin : g_xch
    logic we_x;
    assign we_x = wr_en && enh_b && addr[2] && (addr[1:0] == i[1:0]);
    uart_bank_reg #(.W(DW)) u_x (.clk(clk), .rst_n(rst_q), .we(we_x), .wmask(ALL), .d(wdata), .q(xch[i]));
  end
  assign xon1_o  = xch[0];
  assign xon2_o  = xch[1];
  assign xoff1_o = xch[2];
  assign xoff2_o = xch[3];

  // read multiplexer
  logic div_zero;
  assign div_zero = (dll_o == '0) && (dlm_o == '0);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == A_LCR) rdata = lcr_o;
      else if (enh_b) begin
        if (addr[2])            rdata = xch[addr[1:0]];
        else if (addr == A_0)   rdata = fifo_level;
        else if (addr == A_1)   rdata = fctr_o;
        else if (addr == A_2)   rdata = efr_o;
      end else if (div_b) begin
        if (addr == A_0)        rdata = div_zero ? DEV_REV : dll_o;
        else if (addr == A_1)   rdata = div_zero ? DEV_ID  : dlm_o;
        else if (addr == A_2)   rdata = {5'b0, afr_o};
        else if (addr == A_4)   rdata = mcr_o;
      end else begin
        if (addr == A_1)        rdata = ier_o;
        else if (addr == A_4)   rdata = mcr_o;
      end
    end
  end

  AST_LCR_ANY_BANK: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && addr == A_LCR) |=> (lcr_o == $past(wdata))); // R2
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !(wr_en && div_b && addr[2:1] == 2'b00) |=> ($stable(dll_o) && $stable(dlm_o))); // R3
  AST_ID_ON_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && div_b && addr == A_1 && dll_o == '0 && dlm_o == '0) |-> (rdata == DEV_ID)); // R4
  AST_XCHAR_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !(wr_en && enh_b && addr[2]) |=> $stable({xon1_o, xon2_o, xoff1_o, xoff2_o})); // R6
  AST_IER_LOCK: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && !unlock) |=> (ier_o[7:4] == $past(ier_o[7:4]))); // R8
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_en |-> (rdata == '0)); // R9
endmodule

// File: tb/sim_uart_bank_regs.sv
`timescale 1ns/1ps
module sim_uart_bank_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata, fifo_level, rdata;
  logic [7:0] lcr_o, ier_o, fcr_o, mcr_o, dll_o, dlm_o, trg_o, fctr_o, efr_o;
  logic [7:0] xon1_o, xon2_o, xoff1_o, xoff2_o;
  logic [2:0] afr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  uart_bank_regs u0 (.*);

  // bench model, built from the requirements
  logic [7:0] m_lcr, m_ier, m_fcr, m_mcr, m_dll, m_dlm, m_trg, m_fctr, m_efr;
  logic [2:0] m_afr;
  logic [7:0] m_x [4];

  function automatic int bank_of(logic [7:0] l);
    if (l == 8'hBF) return 2;
    if (l[7])       return 1;
    return 0;
  endfunction

  function automatic logic [7:0] mix(logic [7:0] old, logic [7:0] d, logic [7:0] open_m);
    logic [7:0] m;
    m = m_efr[4] ? 8'hFF : open_m;
    return (old & ~m) | (d & m);
  endfunction

  function automatic logic [7:0] exp_read(int a);
    int b;
    b = bank_of(m_lcr);
    if (a == 3) return m_lcr;
    if (b == 2) begin
      if (a >= 4) return m_x[a-4];
      if (a == 0) return fifo_level;
      if (a == 1) return m_fctr;
      if (a == 2) return m_efr;
    end else if (b == 1) begin
      if (a == 0) return (m_dll == 0 && m_dlm == 0) ? 8'h01 : m_dll;
      if (a == 1) return (m_dll == 0 && m_dlm == 0) ? 8'h12 : m_dlm;
      if (a == 2) return {5'b0, m_afr};
      if (a == 4) return m_mcr;
    end else begin
      if (a == 1) return m_ier;
      if (a == 4) return m_mcr;
    end
    return 8'h00;
  endfunction

  function automatic string tag_of(int a);
    int b;
    b = bank_of(m_lcr);
    if (a == 3) return "R2";
    if (b == 2) return (a >= 4) ? "R6" : "R5";
    if (b == 1) return (a <= 2) ? "R3,R4" : (a == 4 ? "R7,R8" : "R9");
    return (a == 1 || a == 4) ? "R7,R8" : (a == 2 ? "R7" : "R9");
  endfunction

  task automatic model_write(int a, logic [7:0] d);
    int b;
    b = bank_of(m_lcr);
    if (a == 3) m_lcr = d;
    else if (b == 2) begin
      if (a >= 4)      m_x[a-4] = d;
      else if (a == 0) m_trg = d;
      else if (a == 1) m_fctr = d;
      else if (a == 2) m_efr = d;
    end else if (b == 1) begin
      if (a == 0)      m_dll = d;
      else if (a == 1) m_dlm = d;
      else if (a == 2) m_afr = d[2:0];
      else if (a == 4) m_mcr = mix(m_mcr, d, 8'h1F);
    end else begin
      if (a == 1)      m_ier = mix(m_ier, d, 8'h0F);
      else if (a == 2) m_fcr = mix(m_fcr, d, 8'hCF);
      else if (a == 4) m_mcr = mix(m_mcr, d, 8'h1F);
    end
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = a[2:0]; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_check(int a);
    @(negedge clk);
    addr = a[2:0]; rd_en = 1'b1;
    #1 check(tag_of(a), rdata, exp_read(a), $sformatf("read addr %0d lcr %02h", a, m_lcr));
    rd_en = 1'b0;
  endtask

  task automatic port_checks();
    #1;
    check("R7,R8", fcr_o, m_fcr, "fcr_o");
    check("R5", trg_o, m_trg, "trg_o");
    check("R3", afr_o, m_afr, "afr_o");
    check("R8", ier_o, m_ier, "ier_o");
    check("R8", mcr_o, m_mcr, "mcr_o");
    check("R6", {xon1_o, xon2_o, xoff1_o, xoff2_o}[7:0], m_x[3], "xoff2_o");
  endtask

  initial begin : watchdog
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0; fifo_level = 8'h37;
    {m_lcr, m_ier, m_fcr, m_mcr, m_dll, m_dlm, m_trg, m_fctr, m_efr} = '0;
    m_afr = '0;
    for (int i = 0; i < 4; i++) m_x[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values at the ports
    #1;
    check("R1", lcr_o | ier_o | fcr_o | mcr_o | dll_o | dlm_o | trg_o | fctr_o | efr_o, 8'h00, "reset regs");
    check("R1", xon1_o | xon2_o | xoff1_o | xoff2_o | {5'b0, afr_o}, 8'h00, "reset chars");
    // R9: no read strobe gives zero
    check("R9", rdata, 8'h00, "rdata idle");

    // R4: id and revision with zero divisor
    wr(3, 8'h80);
    rd_check(0);
    rd_check(1);
    check("R4", exp_read(1), 8'h12, "model id");

    // sweep banks, unlock bit off and on, every address written then all read back
    for (int b = 0; b < 3; b++) begin
      for (int u = 0; u < 2; u++) begin
        wr(3, 8'hBF);
        wr(2, u ? 8'h10 : 8'h00);
        wr(3, b == 0 ? 8'h03 : (b == 1 ? 8'h83 : 8'hBF));
        for (int a = 0; a < 8; a++) begin
          if (a == 3) continue;
          if (b == 2 && a == 2) continue; // keep the unlock state for this pass
          wr(a, 8'((a * 37 + b * 71 + u * 113) ^ 8'hA5));
          for (int r = 0; r < 8; r++) rd_check(r);
          port_checks();
        end
      end
    end

    // R3: reserved alternate-function bits read zero
    wr(3, 8'h9F);
    wr(2, 8'hFF);
    rd_check(2);
    check("R3", exp_read(2), 8'h07, "afr reserved");

    // R5: fifo level passes through on enhanced-bank reads
    wr(3, 8'hBF);
    fifo_level = 8'hC4;
    rd_check(0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule